// File: doc/BRIEF.md
# Bus Cycle Terminator with Bus Monitor

This block decides, clock by clock, when a bus access issued by a simple master comes to an end. The master asks for an access by pulsing a start strobe with a chip-select index and a beat count. Each beat then ends in one of three ways. It can end automatically once the wait-state count of the selected chip select has elapsed. It can end on an external transfer acknowledge. It can end abnormally on a transfer error.

A transfer error comes from either of two sources. One is an external error pin. The other is an internal bus monitor, which counts the clocks of each beat and trips when a programmed limit is reached before the beat has ended. An error stops the whole access in the clock it is seen, and every beat still outstanding is dropped. One clock after the access ends, the block reports completion to the master. The report carries an error flag and the number of beats that finished normally.

Top module: `bus_term_ctrl`

## Requirements
- R1: A start strobe is accepted only while the block is idle, and `busy_o` rises in the next clock. A start strobe seen while `busy_o` is high has no effect on the access in progress.
- R2: When automatic termination is enabled for the selected chip select, a beat ends normally in the data clock whose zero-based index within the beat equals that chip select's 4-bit wait-state field. Chip select k takes its field from bits [4k+3:4k] of `cs_wait_i` and its enable from bit k of `cs_auto_i`. A field of 0 ends the beat in its first data clock.
- R3: While busy, a high `ack_i` ends the current beat normally in that same clock, whether automatic termination is disabled or its count has not yet elapsed.
- R4: An access runs `start_beats_m1_i`+1 beats. `beat_ack_o` pulses once for each beat that ends normally. After the last beat the access completes with the error flag low and a beat count equal to the number of beats.
- R5: A high `err_i` while busy raises `abort_o` in that clock and ends the access at once. No further beats are run. In the next clock `done_o` is high, `done_err_o` is high, and `done_beats_o` holds the number of beats that ended normally before the abort.
- R6: When an error and a normal termination (acknowledge or wait-state expiry) fall in the same clock, the error wins: `abort_o` is high and `beat_ack_o` stays low.
- R7: With `mon_en_i` high, the bus monitor raises a transfer error in the data clock whose zero-based index within the current beat equals `mon_limit_i`. Its count restarts at every beat termination. With `mon_en_i` low the monitor never raises an error.
- R8: `ack_i` and `err_i` are ignored while idle: they produce no `beat_ack_o`, no `abort_o` and no completion.
- R9: `done_o` is a one-clock pulse in the clock after an access ends. `done_err_o` and `done_beats_o` keep their values until the next completion.
- R10: After reset the block is idle, and `done_o`, `done_err_o` and `done_beats_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Access request strobe |
| start_cs_i | input | CS_W | Chip-select index of the access |
| start_beats_m1_i | input | BEAT_W | Number of beats minus one |
| cs_wait_i | input | NUM_CS*4 | Wait-state field per chip select, 4 bits each |
| cs_auto_i | input | NUM_CS | Automatic termination enable per chip select |
| ack_i | input | 1 | External transfer acknowledge |
| err_i | input | 1 | External transfer error |
| mon_en_i | input | 1 | Bus monitor enable |
| mon_limit_i | input | MON_W | Bus monitor limit in clocks per beat |
| busy_o | output | 1 | Access in progress |
| beat_ack_o | output | 1 | Current beat ends normally this clock |
| abort_o | output | 1 | Access aborted by an error this clock |
| done_o | output | 1 | Completion pulse |
| done_err_o | output | 1 | Completion ended in error |
| done_beats_o | output | BEAT_W+1 | Beats completed normally |

## Verification
The bench builds the block with four chip selects, a 3-bit beat field and a 6-bit monitor limit. The chip selects are set to wait counts of 0, 3 and 15 plus one chip select that relies on the acknowledge only. These settings reach the first-clock termination, the longest wait count, full 8-beat bursts and the 8-beat completion count. A 6-bit limit can be set both below and above the 15-clock wait count, so the bench can show the monitor tripping within a beat and also show it restarting on every beat. The bench covers errors that arrive mid-burst, errors that coincide with an acknowledge, errors that coincide with a wait expiry or a monitor trip, and stray strobes while idle.

// File: rtl/bt_pkg.sv
package bt_pkg;
  localparam int WS_W = 4;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } bt_state_e;

  function automatic int wider(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/bt_ws_mux.sv
module bt_ws_mux
  import bt_pkg::*;
#(
  parameter int NUM_CS = 4,
  parameter int CS_W   = 2
) (
  input  logic [NUM_CS*WS_W-1:0] wait_flat_i,
  input  logic [NUM_CS-1:0]      auto_flat_i,
  input  logic [CS_W-1:0]        sel_i,
  output logic [WS_W-1:0]        ws_o,
  output logic                   auto_en_o
);
  logic [WS_W-1:0] ws_arr [NUM_CS];

  for (genvar g = 0; g < NUM_CS; g++) begin : g_slice
    assign ws_arr[g] = wait_flat_i[g*WS_W +: WS_W];
  end

  always_comb begin
    ws_o      = '0;
    auto_en_o = 1'b0;
    for (int k = 0; k < NUM_CS; k++) begin
      if (sel_i == CS_W'(k)) begin
        ws_o      = ws_arr[k];
        auto_en_o = auto_flat_i[k];
      end
    end
  end
endmodule

// File: rtl/bt_beat_timer.sv
module bt_beat_timer
  import bt_pkg::*;
#(
  parameter int CNT_W = 6,
  parameter int MON_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             run_i,
  input  logic [WS_W-1:0]  ws_i,
  input  logic             auto_en_i,
  input  logic             mon_en_i,
  input  logic [MON_W-1:0] mon_limit_i,
  output logic             auto_hit_o,
  output logic             mon_hit_o
);
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    return (&v) ? v : v + CNT_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (run_i)   cnt_q <= sat_inc(cnt_q);
  end

  assign auto_hit_o = auto_en_i && (cnt_q == CNT_W'(ws_i));
  assign mon_hit_o  = mon_en_i && (cnt_q == CNT_W'(mon_limit_i));

  // R7: the per-beat count restarts after every termination or start
  assert_beat_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> cnt_q == '0)
    else $error("beat timer did not restart");

  // R2: a running beat advances its clock index by one
  assert_timer_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !clear_i && !(&cnt_q)) |=> cnt_q == $past(cnt_q) + CNT_W'(1))
    else $error("beat timer did not advance");
endmodule

// File: rtl/bt_seq.sv
module bt_seq
  import bt_pkg::*;
#(
  parameter int CS_W   = 2,
  parameter int BEAT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [CS_W-1:0]   start_cs_i,
  input  logic [BEAT_W-1:0] start_beats_m1_i,
  input  logic              ack_i,
  input  logic              err_i,
  input  logic              auto_hit_i,
  input  logic              mon_hit_i,
  output logic [CS_W-1:0]   cs_o,
  output logic              busy_o,
  output logic              restart_o,
  output logic              beat_ok_o,
  output logic              abort_o,
  output logic              done_o,
  output logic              done_err_o,
  output logic [BEAT_W:0]   done_beats_o
);
  bt_state_e         state_q;
  logic [CS_W-1:0]   cs_q;
  logic [BEAT_W-1:0] last_q, idx_q;
  logic              done_q, err_q;
  logic [BEAT_W:0]   beats_q;
  logic              accept_w, final_w;

  assign busy_o    = (state_q == ST_RUN);
  assign abort_o   = busy_o && (err_i || mon_hit_i);
  assign beat_ok_o = busy_o && (ack_i || auto_hit_i) && !abort_o;
  assign final_w   = abort_o || (beat_ok_o && (idx_q == last_q));
  assign accept_w  = !busy_o && start_i;
  assign restart_o = accept_w || beat_ok_o;
  assign cs_o      = cs_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cs_q    <= '0;
      last_q  <= '0;
      idx_q   <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      beats_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept_w) begin
        state_q <= ST_RUN;
        cs_q    <= start_cs_i;
        last_q  <= start_beats_m1_i;
        idx_q   <= '0;
      end else if (final_w) begin
        state_q <= ST_IDLE;
        done_q  <= 1'b1;
        err_q   <= abort_o;
        beats_q <= abort_o ? {1'b0, idx_q} : {1'b0, idx_q} + (BEAT_W+1)'(1);
      end else if (beat_ok_o) begin
        idx_q <= idx_q + BEAT_W'(1);
      end
    end
  end

  assign done_o       = done_q;
  assign done_err_o   = err_q;
  assign done_beats_o = beats_q;

  assert_start_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> busy_o)
    else $error("start not accepted");

  assert_start_ignored_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && busy_o && !final_w) |=> (busy_o && $stable(cs_q) && $stable(last_q)))
    else $error("start disturbed a running access");

  assert_full_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !done_err_o) |-> done_beats_o == {1'b0, last_q} + (BEAT_W+1)'(1))
    else $error("wrong completed beat count");

  assert_abort_report_R5: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |=> (done_o && done_err_o && !busy_o))
    else $error("abort not reported");

  assert_err_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && err_i) |-> (abort_o && !beat_ok_o))
    else $error("error lost against normal termination");

  assert_monitor_trip_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && mon_hit_i) |-> abort_o)
    else $error("monitor trip not turned into an abort");

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> (!done_o && !busy_o))
    else $error("idle strobes produced activity");

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o)
    else $error("done held longer than one clock");
endmodule

// File: rtl/bus_term_ctrl.sv
module bus_term_ctrl
  import bt_pkg::*;
#(
  parameter int NUM_CS = 4,
  parameter int BEAT_W = 3,
  parameter int MON_W  = 6,
  localparam int CS_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
  localparam int CNT_W = wider(WS_W, MON_W)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start_i,
  input  logic [CS_W-1:0]        start_cs_i,
  input  logic [BEAT_W-1:0]      start_beats_m1_i,
  input  logic [NUM_CS*WS_W-1:0] cs_wait_i,
  input  logic [NUM_CS-1:0]      cs_auto_i,
  input  logic                   ack_i,
  input  logic                   err_i,
  input  logic                   mon_en_i,
  input  logic [MON_W-1:0]       mon_limit_i,
  output logic                   busy_o,
  output logic                   beat_ack_o,
  output logic                   abort_o,
  output logic                   done_o,
  output logic                   done_err_o,
  output logic [BEAT_W:0]        done_beats_o
);
  logic [CS_W-1:0] cs_w;
  logic [WS_W-1:0] ws_w;
  logic            auto_en_w, auto_hit_w, mon_hit_w, restart_w;

  bt_ws_mux #(.NUM_CS(NUM_CS), .CS_W(CS_W)) u_mux (
    .wait_flat_i (cs_wait_i),
    .auto_flat_i (cs_auto_i),
    .sel_i       (cs_w),
    .ws_o        (ws_w),
    .auto_en_o   (auto_en_w)
  );

  bt_beat_timer #(.CNT_W(CNT_W), .MON_W(MON_W)) u_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear_i     (restart_w),
    .run_i       (busy_o),
    .ws_i        (ws_w),
    .auto_en_i   (auto_en_w),
    .mon_en_i    (mon_en_i),
    .mon_limit_i (mon_limit_i),
    .auto_hit_o  (auto_hit_w),
    .mon_hit_o   (mon_hit_w)
  );

  bt_seq #(.CS_W(CS_W), .BEAT_W(BEAT_W)) u_seq (
    .clk              (clk),
    .rst_n            (rst_n),
    .start_i          (start_i),
    .start_cs_i       (start_cs_i),
    .start_beats_m1_i (start_beats_m1_i),
    .ack_i            (ack_i),
    .err_i            (err_i),
    .auto_hit_i       (auto_hit_w),
    .mon_hit_i        (mon_hit_w),
    .cs_o             (cs_w),
    .busy_o           (busy_o),
    .restart_o        (restart_w),
    .beat_ok_o        (beat_ack_o),
    .abort_o          (abort_o),
    .done_o           (done_o),
    .done_err_o       (done_err_o),
    .done_beats_o     (done_beats_o)
  );
endmodule

// File: tb/bus_term_ctrl_tb.sv
`timescale 1ns/100ps
module bus_term_ctrl_tb;
  localparam int NUM_CS = 4, BEAT_W = 3, MON_W = 6, CS_W = 2, CNT_MAX = 63;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic              start_i = 1'b0;
  logic [CS_W-1:0]   start_cs_i = '0;
  logic [BEAT_W-1:0] start_beats_m1_i = '0;
  logic [15:0]       cs_wait_i = {4'd5, 4'd15, 4'd3, 4'd0};
  logic [3:0]        cs_auto_i = 4'b0111;
  logic              ack_i = 1'b0, err_i = 1'b0, mon_en_i = 1'b0;
  logic [MON_W-1:0]  mon_limit_i = '0;
  logic              busy_o, beat_ack_o, abort_o, done_o, done_err_o;
  logic [BEAT_W:0]   done_beats_o;

  bus_term_ctrl #(.NUM_CS(NUM_CS), .BEAT_W(BEAT_W), .MON_W(MON_W)) u_dut (.*);

  int cfg_ws[NUM_CS]   = '{0, 3, 15, 5};
  int cfg_auto[NUM_CS] = '{1, 1, 1, 0};

  // reference model state
  int m_busy = 0, m_cs = 0, m_last = 0, m_idx = 0, m_cnt = 0;
  int m_done = 0, m_err = 0, m_count = 0;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  string cur_req = "R10";

  task automatic model_eval(output int ok, output int bad);
    int normal;
    ok = 0; bad = 0;
    if (m_busy != 0) begin
      normal = ((cfg_auto[m_cs] != 0) && (m_cnt == cfg_ws[m_cs])) || (ack_i == 1'b1) ? 1 : 0;
      bad    = (err_i == 1'b1) || (mon_en_i && (m_cnt == int'(mon_limit_i))) ? 1 : 0;
      ok     = (normal != 0 && bad == 0) ? 1 : 0;
    end
  endtask

  always @(posedge clk) begin : model
    int ok_v, bad_v;
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_err = 0; m_count = 0; m_cnt = 0;
    end else begin
      model_eval(ok_v, bad_v);
      m_done = 0;
      if (m_busy == 0) begin
        if (start_i) begin
          m_busy = 1; m_cs = int'(start_cs_i); m_last = int'(start_beats_m1_i);
          m_idx = 0; m_cnt = 0;
        end
      end else if (bad_v != 0) begin
        m_busy = 0; m_done = 1; m_err = 1; m_count = m_idx;
      end else if (ok_v != 0 && m_idx == m_last) begin
        m_busy = 0; m_done = 1; m_err = 0; m_count = m_idx + 1;
      end else if (ok_v != 0) begin
        m_idx++; m_cnt = 0;
      end else begin
        m_cnt = (m_cnt < CNT_MAX) ? m_cnt + 1 : CNT_MAX;
      end
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic cmp();
    int ok, bad;
    #1;
    model_eval(ok, bad);
    chk(cur_req, "busy", int'(busy_o), m_busy);
    chk(cur_req, "beat_ack", int'(beat_ack_o), ok);
    chk(cur_req, "abort", int'(abort_o), bad);
    chk(cur_req, "done", int'(done_o), m_done);
    chk(cur_req, "done_err", int'(done_err_o), m_err);
    chk(cur_req, "done_beats", int'(done_beats_o), m_count);
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // ack_at: clock index in a beat that gets ack; err_at: active clock that gets err
  task automatic run(int cs, int bm1, int ack_at, int err_at, int hold);
    int tot = 0, bclk = 0;
    tick();
    start_i = 1'b1; start_cs_i = CS_W'(cs); start_beats_m1_i = BEAT_W'(bm1);
    ack_i = 1'b0; err_i = 1'b0;
    cmp();
    for (int i = 0; i < 300; i++) begin
      tick();
      start_i = (hold != 0 && tot < 3);
      start_cs_i = CS_W'(cs + hold);
      ack_i = (ack_at >= 0 && bclk == ack_at);
      err_i = (err_at >= 0 && tot == err_at);
      cmp();
      if (!busy_o) break;
      if (beat_ack_o) bclk = 0; else bclk++;
      tot++;
    end
    tick();
    start_i = 1'b0; ack_i = 1'b0; err_i = 1'b0;
    cmp();
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    cur_req = "R10";
    tick(); cmp(); tick(); cmp();
    rst_n = 1'b1;
    tick(); cmp();

    cur_req = "R2";
    run(0, 0, -1, -1, 0);
    run(1, 3, -1, -1, 0);
    run(2, 0, -1, -1, 0);

    cur_req = "R3";
    run(3, 1, 2, -1, 0);
    run(2, 0, 4, -1, 0);

    cur_req = "R4";
    run(1, 7, -1, -1, 0);
    run(0, 7, -1, -1, 0);

    cur_req = "R5";
    run(1, 2, -1, 6, 0);
    run(0, 7, -1, 5, 0);

    cur_req = "R6";
    run(0, 0, -1, 0, 0);
    run(3, 1, 2, 2, 0);

    cur_req = "R7";
    mon_en_i = 1'b1; mon_limit_i = 6'd5;
    run(3, 0, -1, -1, 0);
    mon_limit_i = 6'd4;
    run(1, 3, -1, -1, 0);
    mon_limit_i = 6'd3;
    run(1, 2, -1, -1, 0);
    mon_limit_i = 6'd10;
    run(2, 2, -1, -1, 0);
    mon_limit_i = 6'd20;
    run(2, 1, -1, -1, 0);
    mon_en_i = 1'b0; mon_limit_i = 6'd0;
    run(3, 0, 9, -1, 0);

    cur_req = "R8";
    tick(); ack_i = 1'b1; err_i = 1'b1; cmp();
    tick(); cmp();
    tick(); ack_i = 1'b0; err_i = 1'b0; cmp();
    tick(); cmp();

    cur_req = "R1";
    run(1, 1, -1, -1, 1);

    cur_req = "R9";
    run(3, 0, 1, -1, 0);
    tick(); cmp();
    tick(); cmp();

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule